// File: doc/BRIEF.md
# Dual-Address Hardware Breakpoint Unit

This block is one hardware breakpoint unit that sits beside a CPU and watches its buses. In instruction mode it compares the fetch address against two programmable addresses. In data mode it compares the data-access address instead, and each access qualifies only when the matching read or write enable is set. When an access qualifies, the unit records the hit in a sticky status word and raises a one-cycle break request toward the run-control logic.

A debug host configures the unit through a small register port with four registers: a control word, a status word that is cleared by writing ones, and two address registers. The address registers read back exactly as written, so the host can find out whether a unit is fitted. To watch a single address, the host loads the same value into both address registers. A system may instantiate several identical units.

Top module: `bkpt_unit`

## Requirements
- R1: A synchronous active-high reset clears the control word, the status word, both address registers, the read data and the break request to zero.
- R2: Register select codes are 0 for control, 1 for status, 2 for address A and 3 for address B. The value of the selected register appears on `rd_data` one clock after the select, zero-extended. The control word keeps all `CTL_W` written bits, including bit 5, and the address registers hold exactly the value written.
- R3: While control bit 2 (enable) is clear, which includes a control word of 0, no access raises a break or sets any status bit.
- R4: In data mode (control bit 3 = 0), a read access qualifies when control bit 0 is set. A write access qualifies when control bit 1 is set.
- R5: A data read while control bit 0 is clear, a data write while control bit 1 is clear, and any access whose address matches neither register have no effect on status or on the break request.
- R6: In instruction mode (control bit 3 = 1), a valid fetch whose address matches a register qualifies whatever the values of bits 0 and 1. Data accesses are ignored in this mode.
- R7: The two address comparators act independently. When both registers hold the same value, one access sets the hit bits for both.
- R8: Status bit 0 records a read or fetch hit on address A, bit 1 a write hit on A, bit 2 a read or fetch hit on B, and bit 3 a write hit on B. Each bit stays set until it is cleared.
- R9: A write to the status register clears every bit written as one (0xFF clears all). A hit arriving in the same cycle as the clear leaves its bit set.
- R10: `brk_req` is high in exactly the cycle that follows each cycle with at least one qualifying hit, and low in every other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_sel | input | SEL_W | Register select for both read and write |
| reg_wr | input | 1 | Host write strobe |
| wr_data | input | ADDR_W | Host write data |
| rd_data | output | ADDR_W | Registered read data of the selected register |
| fetch_vld | input | 1 | Instruction fetch in progress |
| fetch_addr | input | ADDR_W | Instruction fetch address |
| dacc_rd | input | 1 | Data read strobe |
| dacc_wr | input | 1 | Data write strobe |
| dacc_addr | input | ADDR_W | Data access address |
| brk_req | output | 1 | One-cycle break request |

## Verification
The bench builds the unit with its default parameters: 16-bit addresses, an 8-bit control word and two comparators. This gives a two-bit select and a four-bit status word, so every status bit and every register code can be reached. These widths allow the presence-test pattern 0x1234 and the 0x20-based control values to be written and read back directly. A behavioural model of the hits, the sticky status and the registered read path is compared with the outputs on every clock. The directed sequences cover both modes, disabled units, unqualified strobes, coinciding addresses, partial clears and a clear that collides with a hit.

// File: rtl/bkpt_pkg.sv
package bkpt_pkg;
  // control word bit positions (decoded by the comparators)
  localparam int CB_RD    = 0;
  localparam int CB_WR    = 1;
  localparam int CB_EN    = 2;
  localparam int CB_FETCH = 3;
  // register select codes
  localparam int SEL_CTL       = 0;
  localparam int SEL_STAT      = 1;
  localparam int SEL_ADDR_BASE = 2;
endpackage

// File: rtl/bkpt_regs.sv
module bkpt_regs #(
  parameter int ADDR_W   = 16,
  parameter int CTL_W    = 8,
  parameter int NUM_ADDR = 2,
  parameter int SEL_W    = 2
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic                             reg_wr,
  input  logic [SEL_W-1:0]                 reg_sel,
  input  logic [ADDR_W-1:0]                wr_data,
  output logic [CTL_W-1:0]                 ctl_q,
  output logic [NUM_ADDR-1:0][ADDR_W-1:0]  addr_q
);
  import bkpt_pkg::*;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q <= '0;
    end else if (reg_wr && reg_sel == SEL_W'(SEL_CTL)) begin
      ctl_q <= wr_data[CTL_W-1:0];
    end
  end

  for (genvar k = 0; k < NUM_ADDR; k++) begin : g_addr
    always_ff @(posedge clk) begin
      if (rst) begin
        addr_q[k] <= '0;
      end else if (reg_wr && reg_sel == SEL_W'(SEL_ADDR_BASE + k)) begin
        addr_q[k] <= wr_data;
      end
    end
  end
endmodule

// File: rtl/bkpt_match.sv
module bkpt_match #(
  parameter int ADDR_W   = 16,
  parameter int CTL_W    = 8,
  parameter int NUM_ADDR = 2
) (
  input  logic [CTL_W-1:0]                 ctl,
  input  logic [NUM_ADDR-1:0][ADDR_W-1:0]  addr,
  input  logic                             fetch_vld,
  input  logic [ADDR_W-1:0]                fetch_addr,
  input  logic                             dacc_rd,
  input  logic                             dacc_wr,
  input  logic [ADDR_W-1:0]                dacc_addr,
  output logic [NUM_ADDR-1:0]              hit_rf,
  output logic [NUM_ADDR-1:0]              hit_wr
);
  import bkpt_pkg::*;

  logic en, fmode, rd_q, wr_q;
  assign en    = ctl[CB_EN];
  assign fmode = ctl[CB_FETCH];
  assign rd_q  = dacc_rd && ctl[CB_RD];
  assign wr_q  = dacc_wr && ctl[CB_WR];

  for (genvar k = 0; k < NUM_ADDR; k++) begin : g_cmp
    logic f_eq, d_eq;
    assign f_eq = fetch_vld && (fetch_addr == addr[k]);
    assign d_eq = (dacc_addr == addr[k]);
    assign hit_rf[k] = en && (fmode ? f_eq : (rd_q && d_eq));
    assign hit_wr[k] = en && !fmode && wr_q && d_eq;
  end
endmodule

// File: rtl/bkpt_status.sv
module bkpt_status #(
  parameter int NUM_ADDR = 2,
  localparam int STAT_W  = 2 * NUM_ADDR
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_ADDR-1:0] hit_rf,
  input  logic [NUM_ADDR-1:0] hit_wr,
  input  logic                clr_en,
  input  logic [STAT_W-1:0]   clr_mask,
  output logic [STAT_W-1:0]   stat_q,
  output logic                brk_req
);
  logic [STAT_W-1:0] set_vec;

  for (genvar k = 0; k < NUM_ADDR; k++) begin : g_pack
    assign set_vec[2*k]   = hit_rf[k];
    assign set_vec[2*k+1] = hit_wr[k];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stat_q  <= '0;
      brk_req <= 1'b0;
    end else begin
      // new hits win over a simultaneous clear
      stat_q  <= (stat_q & ~(clr_en ? clr_mask : '0)) | set_vec;
      brk_req <= |set_vec;
    end
  end
endmodule

// File: rtl/bkpt_unit.sv
module bkpt_unit #(
  parameter int ADDR_W   = 16,
  parameter int CTL_W    = 8,
  parameter int NUM_ADDR = 2,
  localparam int SEL_W   = $clog2(NUM_ADDR + 2),
  localparam int STAT_W  = 2 * NUM_ADDR
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [SEL_W-1:0]  reg_sel,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] wr_data,
  output logic [ADDR_W-1:0] rd_data,
  input  logic              fetch_vld,
  input  logic [ADDR_W-1:0] fetch_addr,
  input  logic              dacc_rd,
  input  logic              dacc_wr,
  input  logic [ADDR_W-1:0] dacc_addr,
  output logic              brk_req
);
  import bkpt_pkg::*;

  logic [CTL_W-1:0]                ctl_q;
  logic [NUM_ADDR-1:0][ADDR_W-1:0] addr_q;
  logic [NUM_ADDR-1:0]             hit_rf, hit_wr;
  logic [STAT_W-1:0]               stat_q;
  logic                            stat_clr;
  logic [ADDR_W-1:0]               rd_next;

  bkpt_regs #(.ADDR_W(ADDR_W), .CTL_W(CTL_W), .NUM_ADDR(NUM_ADDR), .SEL_W(SEL_W)) regs_i (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_sel(reg_sel), .wr_data(wr_data),
    .ctl_q(ctl_q), .addr_q(addr_q)
  );

  bkpt_match #(.ADDR_W(ADDR_W), .CTL_W(CTL_W), .NUM_ADDR(NUM_ADDR)) match_i (
    .ctl(ctl_q), .addr(addr_q), .fetch_vld(fetch_vld), .fetch_addr(fetch_addr),
    .dacc_rd(dacc_rd), .dacc_wr(dacc_wr), .dacc_addr(dacc_addr),
    .hit_rf(hit_rf), .hit_wr(hit_wr)
  );

  assign stat_clr = reg_wr && (reg_sel == SEL_W'(SEL_STAT));

  bkpt_status #(.NUM_ADDR(NUM_ADDR)) status_i (
    .clk(clk), .rst(rst), .hit_rf(hit_rf), .hit_wr(hit_wr),
    .clr_en(stat_clr), .clr_mask(wr_data[STAT_W-1:0]),
    .stat_q(stat_q), .brk_req(brk_req)
  );

  always_comb begin
    rd_next = '0;
    if (reg_sel == SEL_W'(SEL_CTL)) rd_next[CTL_W-1:0] = ctl_q;
    if (reg_sel == SEL_W'(SEL_STAT)) rd_next[STAT_W-1:0] = stat_q;
    for (int k = 0; k < NUM_ADDR; k++) begin
      if (reg_sel == SEL_W'(SEL_ADDR_BASE + k)) rd_next = addr_q[k];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= rd_next;
  end
endmodule

// File: rtl/bkpt_unit_chk.sv
module bkpt_unit_chk #(
  parameter int ADDR_W = 16,
  parameter int CTL_W  = 8,
  parameter int SEL_W  = 2,
  parameter int STAT_W = 4
) (
  input logic              clk,
  input logic              rst,
  input logic [SEL_W-1:0]  reg_sel,
  input logic              reg_wr,
  input logic [ADDR_W-1:0] wr_data,
  input logic              fetch_vld,
  input logic [ADDR_W-1:0] fetch_addr,
  input logic [CTL_W-1:0]  ctl,
  input logic [STAT_W-1:0] stat,
  input logic [ADDR_W-1:0] addr0,
  input logic              brk_req
);
  assert_reset_quiet_R1: assert property (@(posedge clk)
    rst |=> (!brk_req && stat == '0 && ctl == '0));

  assert_addr_readback_R2: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && reg_sel == SEL_W'(2)) |=> (addr0 == $past(wr_data)));

  assert_disabled_silent_R3: assert property (@(posedge clk) disable iff (rst)
    !ctl[2] |=> !brk_req);

  assert_fetch_hit_R6: assert property (@(posedge clk) disable iff (rst)
    (ctl[2] && ctl[3] && fetch_vld && fetch_addr == addr0) |=> (brk_req && stat[0]));

  assert_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    !(reg_wr && reg_sel == SEL_W'(1)) |=> ((stat & $past(stat)) == $past(stat)));

  assert_brk_recorded_R10: assert property (@(posedge clk) disable iff (rst)
    brk_req |-> (stat != '0));
endmodule

bind bkpt_unit bkpt_unit_chk #(.ADDR_W(ADDR_W), .CTL_W(CTL_W), .SEL_W(SEL_W), .STAT_W(STAT_W)) chk_i (
  .clk(clk), .rst(rst), .reg_sel(reg_sel), .reg_wr(reg_wr), .wr_data(wr_data),
  .fetch_vld(fetch_vld), .fetch_addr(fetch_addr), .ctl(ctl_q), .stat(stat_q),
  .addr0(addr_q[0]), .brk_req(brk_req)
);

// File: tb/bkpt_unit_tb_top.sv
module bkpt_unit_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 16;
  localparam int CW = 8;
  localparam int WATCHDOG = 100000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [1:0] reg_sel = '0;
  logic reg_wr = 1'b0;
  logic [AW-1:0] wr_data = '0;
  logic [AW-1:0] rd_data;
  logic fetch_vld = 1'b0;
  logic [AW-1:0] fetch_addr = '0;
  logic dacc_rd = 1'b0, dacc_wr = 1'b0;
  logic [AW-1:0] dacc_addr = '0;
  logic brk_req;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bkpt_unit #(.ADDR_W(AW), .CTL_W(CW), .NUM_ADDR(2)) dut_i (
    .clk(clk), .rst(rst), .reg_sel(reg_sel), .reg_wr(reg_wr), .wr_data(wr_data),
    .rd_data(rd_data), .fetch_vld(fetch_vld), .fetch_addr(fetch_addr),
    .dacc_rd(dacc_rd), .dacc_wr(dacc_wr), .dacc_addr(dacc_addr), .brk_req(brk_req)
  );

  // behavioural reference model
  int m_ctl = 0, m_stat = 0, m_rd = 0;
  int m_addr[2] = '{0, 0};
  bit m_brk = 0;

  always @(posedge clk) begin
    int hits, clr, rdv;
    if (rst) begin
      m_ctl = 0; m_stat = 0; m_addr[0] = 0; m_addr[1] = 0; m_brk = 0; m_rd = 0;
    end else begin
      hits = 0;
      for (int k = 0; k < 2; k++) begin
        bit en, fm, dm;
        en = m_ctl[2]; fm = m_ctl[3]; dm = (int'(dacc_addr) == m_addr[k]);
        if (en && fm && fetch_vld && int'(fetch_addr) == m_addr[k]) hits |= 1 << (2*k);
        if (en && !fm && dacc_rd && m_ctl[0] && dm) hits |= 1 << (2*k);
        if (en && !fm && dacc_wr && m_ctl[1] && dm) hits |= 1 << (2*k+1);
      end
      case (reg_sel)
        2'd0: rdv = m_ctl;
        2'd1: rdv = m_stat;
        2'd2: rdv = m_addr[0];
        default: rdv = m_addr[1];
      endcase
      clr = (reg_wr && reg_sel == 2'd1) ? int'(wr_data[3:0]) : 0;
      m_stat = (m_stat & ~clr) | hits;
      m_brk = (hits != 0);
      m_rd = rdv;
      if (reg_wr && reg_sel == 2'd0) m_ctl = int'(wr_data[CW-1:0]);
      if (reg_wr && reg_sel == 2'd2) m_addr[0] = int'(wr_data);
      if (reg_wr && reg_sel == 2'd3) m_addr[1] = int'(wr_data);
    end
  end

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: act=0x%0h exp=0x%0h at %0t", req, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (!rst && !done) begin
      chk("R10 brk_req vs model", int'(brk_req), int'(m_brk));
      chk("R2 rd_data vs model", int'(rd_data), m_rd);
    end
  end

  task automatic host_wr(input logic [1:0] sel, input logic [AW-1:0] d);
    @(negedge clk); reg_sel = sel; reg_wr = 1'b1; wr_data = d;
    @(negedge clk); reg_wr = 1'b0; wr_data = '0;
  endtask

  task automatic host_rd(input logic [1:0] sel, output int v);
    @(negedge clk); reg_sel = sel;
    @(negedge clk); v = int'(rd_data);
  endtask

  // one access cycle; returns brk_req seen in the following cycle
  task automatic access(input bit f, input bit r, input bit w, input logic [AW-1:0] a, output int b);
    @(negedge clk);
    fetch_vld = f; fetch_addr = a; dacc_rd = r; dacc_wr = w; dacc_addr = a;
    @(negedge clk);
    fetch_vld = 0; dacc_rd = 0; dacc_wr = 0;
    b = int'(brk_req);
  endtask

  initial begin
    int v, b;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk("R1 brk after reset", int'(brk_req), 0);
    host_rd(2'd0, v); chk("R1 ctl reset", v, 0);
    host_rd(2'd1, v); chk("R1 stat reset", v, 0);
    host_rd(2'd2, v); chk("R1 addrA reset", v, 0);
    host_rd(2'd3, v); chk("R1 addrB reset", v, 0);
    // R2 readback
    host_wr(2'd2, 16'h1234); host_rd(2'd2, v); chk("R2 addrA readback", v, 'h1234);
    host_wr(2'd3, 16'hBEEF); host_rd(2'd3, v); chk("R2 addrB readback", v, 'hBEEF);
    host_wr(2'd0, 16'h00AB); host_rd(2'd0, v); chk("R2 ctl keeps all bits", v, 'hAB);
    // R3 disabled
    host_wr(2'd0, 16'h0000);
    access(0, 1, 1, 16'h1234, b); chk("R3 ctl=0 no break", b, 0);
    host_wr(2'd0, 16'h002B);
    access(1, 1, 1, 16'h1234, b); chk("R3 enable clear no break", b, 0);
    host_rd(2'd1, v); chk("R3 no status", v, 0);
    // R4/R10 data read on A
    host_wr(2'd0, 16'h0025);
    access(0, 1, 0, 16'h1234, b); chk("R10 break after read hit", b, 1);
    @(negedge clk); chk("R10 single pulse", int'(brk_req), 0);
    host_rd(2'd1, v); chk("R4 R8 read hit on A sets bit0", v, 'h1);
    // R5 unqualified write, mismatched address
    access(0, 0, 1, 16'h1234, b); chk("R5 write not enabled", b, 0);
    access(0, 1, 0, 16'h1235, b); chk("R5 address mismatch", b, 0);
    host_rd(2'd1, v); chk("R5 R8 status unchanged", v, 'h1);
    // R9 clear all
    host_wr(2'd1, 16'h00FF); host_rd(2'd1, v); chk("R9 clear all", v, 0);
    // R4 write on B
    host_wr(2'd0, 16'h0026);
    access(0, 0, 1, 16'hBEEF, b); chk("R4 write hit on B", b, 1);
    access(0, 1, 0, 16'hBEEF, b); chk("R5 read not enabled", b, 0);
    host_rd(2'd1, v); chk("R8 write hit on B sets bit3", v, 'h8);
    // R9 partial clear
    host_wr(2'd0, 16'h0025);
    access(0, 1, 0, 16'h1234, b);
    host_wr(2'd1, 16'h0001); host_rd(2'd1, v); chk("R9 partial clear", v, 'h8);
    host_wr(2'd1, 16'h00FF);
    // R6 fetch mode
    host_wr(2'd0, 16'h002C);
    access(1, 0, 0, 16'h1234, b); chk("R6 fetch hit without rd/wr bits", b, 1);
    access(0, 1, 1, 16'hBEEF, b); chk("R6 data ignored in fetch mode", b, 0);
    host_wr(2'd0, 16'h002F);
    access(1, 0, 0, 16'hBEEF, b); chk("R6 fetch hit on B", b, 1);
    host_rd(2'd1, v); chk("R6 R8 fetch hits bits0 and 2", v, 'h5);
    access(1, 0, 0, 16'h4321, b); chk("R6 fetch mismatch", b, 0);
    host_wr(2'd1, 16'h00FF);
    // R7 both registers same address
    host_wr(2'd3, 16'h1234); host_wr(2'd0, 16'h0027);
    access(0, 1, 0, 16'h1234, b); chk("R7 shared address break", b, 1);
    host_rd(2'd1, v); chk("R7 read sets both A and B", v, 'h5);
    access(0, 0, 1, 16'h1234, b);
    host_rd(2'd1, v); chk("R7 write sets both A and B", v, 'hF);
    // R9 hit wins over simultaneous clear
    host_wr(2'd1, 16'h00FF);
    @(negedge clk);
    reg_sel = 2'd1; reg_wr = 1'b1; wr_data = 16'h00FF;
    dacc_rd = 1'b1; dacc_addr = 16'h1234;
    @(negedge clk);
    reg_wr = 1'b0; dacc_rd = 1'b0;
    chk("R9 R10 break on colliding hit", int'(brk_req), 1);
    @(negedge clk); chk("R9 hit survives clear", int'(rd_data), 'h5);
    // R10 back-to-back accesses give back-to-back pulses
    host_wr(2'd1, 16'h00FF);
    @(negedge clk); dacc_rd = 1'b1; dacc_addr = 16'h1234;
    @(negedge clk); dacc_rd = 1'b1;
    @(negedge clk); dacc_rd = 1'b0; chk("R10 second consecutive pulse", int'(brk_req), 1);
    @(negedge clk); chk("R10 pulse ends", int'(brk_req), 0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R10 watchdog: act=running exp=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule